// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block sits behind a two-wire serial protocol engine in a small nonvolatile memory. It receives decoded events from that engine: a word address, a string of data bytes, and the end-of-transaction condition. It places the data bytes in a sixteen-slot page buffer. A four-bit slot pointer picks the slot for each byte and wraps inside the page, while the five page bits stay fixed. Nothing reaches the 512-byte array while bytes are still arriving.

When the end-of-transaction strobe arrives, the controller decides whether to program. It programs only when at least one slot holds a byte and the write-protect input is low. If it programs, it raises `busy`. It walks all sixteen slots and stores only those loaded since the last address load. It then holds `busy` for a self-timed programming period of `WRITE_CLKS` clocks. After that it clears the slot mask and returns to collecting. While `busy` is high, every incoming strobe is dropped.

Within one cycle, `stop` takes precedence over `addr_load`, and `addr_load` takes precedence over `byte_valid`. A combinational read port lets the surrounding logic or a test inspect any array location.

States:
- **ST_COLLECT** (busy low): accepts strobes.
- **ST_COMMIT**: one cycle per slot, sixteen cycles in all.
- **ST_SETTLE**: the timed programming period.

Transitions:
- **go_commit** (ST_COLLECT to ST_COMMIT): a stop with a nonempty mask and write-protect low.
- **last_slot** (ST_COMMIT to ST_SETTLE): after slot 15.
- **timer_done** (ST_SETTLE to ST_COLLECT): when the timer expires.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `busy` is low and every array location reads 0xFF (erased).
- R2: An address load, one data byte and a stop with `wp` low store that byte at exactly that address and leave every other location unchanged.
- R3: Each accepted byte advances only address bits [3:0], modulo 16, while bits [8:4] stay fixed. A page started mid-page therefore continues at slot 0 of the same page.
- R4: When more than 16 bytes arrive before stop, a later byte replaces the earlier byte held in the same slot. The array receives the latest value for each slot.
- R5: The array is not modified before the stop strobe: a location being loaded still reads its old value.
- R6: A stop while `wp` is high writes nothing and leaves `busy` low. The collected bytes are discarded.
- R7: A stop with no byte accepted since the last address load or stop starts no write, and `busy` stays low.
- R8: A committing stop raises `busy` on the next clock. `busy` then stays high for exactly 16 + `WRITE_CLKS` cycles.
- R9: `addr_load`, `byte_valid` and `stop` asserted while `busy` is high have no effect on the array or on the next transaction.
- R10: Only slots loaded since the latest address load are programmed. The slot mask is cleared by an address load and when a write completes, so stale buffer bytes are never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load word address strobe |
| addr_in | input | 9 | Word address: [8:4] page, [3:0] slot |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | End-of-transaction strobe |
| wp | input | 1 | Write protect, high blocks programming |
| busy | output | 1 | Commit or timed programming in progress |
| rd_addr | input | 9 | Read port address |
| rd_data | output | 8 | Array contents at `rd_addr` |

## Verification
The bench sweeps all 512 locations against an arithmetic model after each transaction. This exposes a pointer that carries into the page bits: it would write into the following page. It also exposes a design that programs every slot instead of only masked ones: stale bytes from an earlier page would appear. The bench overruns a page with 20 bytes from a mid-page start, which catches a buffer that keeps the first value of a slot instead of the last. It also measures the exact `busy` length, and sends stops with write-protect high, with an empty mask, and during `busy`. These catch a controller that programs when it should discard, miscounts the timed period, or accepts strobes while busy.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_COMMIT  = 2'd1,
        ST_SETTLE  = 2'd2
    } pgw_state_e;
endpackage

// File: rtl/pgw_slot_buf.sv
module pgw_slot_buf #(
    parameter int SLOTS = 16,
    parameter int DW    = 8,
    localparam int IW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          clr,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          any_valid
);
    logic [SLOTS-1:0] vld;
    logic [DW-1:0]    slot_data [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic          v_q;
        logic [DW-1:0] d_q;
        logic          hit;

        assign hit = wr_en && (wr_idx == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else begin
                if (clr) begin
                    v_q <= 1'b0;
                end else if (hit) begin
                    v_q <= 1'b1;
                end
                if (hit) begin
                    d_q <= wr_data;
                end
            end
        end

        assign vld[g]       = v_q;
        assign slot_data[g] = d_q;
    end

    assign rd_data   = slot_data[rd_idx];
    assign rd_valid  = vld[rd_idx];
    assign any_valid = |vld;

    // The mask is empty in the cycle after a clear.
    p_mask_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_valid);
endmodule

// File: rtl/pgw_wtimer.sv
module pgw_wtimer #(
    parameter int  CYCLES = 2000000,
    localparam int CW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= CW'(CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done = run_q && (cnt_q == '0);

    // The timer fires once, then goes idle.
    p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);
endmodule

// File: rtl/pgw_mem.sv
module pgw_mem #(
    parameter int          DEPTH  = 512,
    parameter int          DW     = 8,
    parameter logic [7:0]  ERASED = 8'hFF,
    localparam int         AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= DW'(ERASED);
            end
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

    // A location not being written keeps its value.
    p_cell_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || waddr != raddr) |=> (rdata == $past(rdata)) || (raddr != $past(raddr)));
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import pgw_pkg::*;
#(
    parameter int  DW         = 8,
    parameter int  PAGE_BYTES = 16,
    parameter int  PAGES      = 32,
    parameter int  WRITE_CLKS = 2000000,
    localparam int SLOT_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = $clog2(PAGES),
    localparam int AW         = SLOT_W + PAGE_W,
    localparam int DEPTH      = PAGES * PAGE_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_in,
    input  logic          byte_valid,
    input  logic [DW-1:0] byte_data,
    input  logic          stop,
    input  logic          wp,
    output logic          busy,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAGE_BYTES - 1);

    pgw_state_e        state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [SLOT_W-1:0] ptr_q;
    logic [SLOT_W-1:0] slot_q;

    logic              collecting;
    logic              accept_stop, accept_addr, accept_byte, go_commit;
    logic              buf_clr, any_valid, slot_valid;
    logic [DW-1:0]     slot_byte;
    logic              tmr_start, tmr_done;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;

    assign collecting  = (state_q == ST_COLLECT);
    assign accept_stop = collecting && stop;
    assign accept_addr = collecting && !stop && addr_load;
    assign accept_byte = collecting && !stop && !addr_load && byte_valid;
    assign go_commit   = accept_stop && any_valid && !wp;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COLLECT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (go_commit)             state_d = ST_COMMIT;
            ST_COMMIT:  if (slot_q == LAST_SLOT)   state_d = ST_SETTLE;
            ST_SETTLE:  if (tmr_done)              state_d = ST_COLLECT;
            default:                               state_d = ST_COLLECT;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = !collecting;
        mem_we    = (state_q == ST_COMMIT) && slot_valid;
        mem_waddr = {page_q, slot_q};
        tmr_start = (state_q == ST_COMMIT) && (slot_q == LAST_SLOT);
        buf_clr   = accept_addr
                  || (accept_stop && !go_commit)
                  || ((state_q == ST_SETTLE) && tmr_done);
    end

    // Address pointer and commit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ptr_q  <= '0;
            slot_q <= '0;
        end else begin
            if (accept_addr) begin
                page_q <= addr_in[AW-1:SLOT_W];
                ptr_q  <= addr_in[SLOT_W-1:0];
            end else if (accept_byte) begin
                ptr_q  <= ptr_q + 1'b1;
            end
            if (state_q == ST_COMMIT) begin
                slot_q <= slot_q + 1'b1;
            end else begin
                slot_q <= '0;
            end
        end
    end

    pgw_slot_buf #(.SLOTS(PAGE_BYTES), .DW(DW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept_byte),
        .wr_idx    (ptr_q),
        .wr_data   (byte_data),
        .clr       (buf_clr),
        .rd_idx    (slot_q),
        .rd_data   (slot_byte),
        .rd_valid  (slot_valid),
        .any_valid (any_valid)
    );

    pgw_wtimer #(.CYCLES(WRITE_CLKS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    pgw_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (slot_byte),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // The slot pointer steps by one and wraps within the page.
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_byte |=> ptr_q == SLOT_W'($past(ptr_q) + 1'b1));
    // No array write happens outside the busy period.
    p_no_early_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);
    // Write protect blocks programming.
    p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && wp && !busy) |=> !busy);
    // An empty stop does not start a write.
    p_empty_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !busy && !any_valid) |=> !busy);
    // Busy rises only after an unprotected stop.
    p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop && !wp));
    // Strobes that arrive while busy leave the pointer unchanged.
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr_q) && $stable(page_q));
endmodule

// File: tb/sim_page_commit_ctrl.sv
module sim_page_commit_ctrl;
    localparam int T = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [8:0] addr_in = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop = 1'b0;
    logic       wp = 1'b0;
    logic       busy;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;

    logic [7:0]  exp_mem [512];
    logic [7:0]  m_buf [16];
    logic [15:0] m_mask;
    int          m_page, m_ptr;

    always #2.5 clk = ~clk;

    page_commit_ctrl #(.WRITE_CLKS(T)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop(stop), .wp(wp),
        .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 512; a++) begin
            rd_addr = 9'(a);
            #0.1;
            chk(rd_data == exp_mem[a], req, rd_data, exp_mem[a]);
        end
    endtask

    task automatic set_addr(input int a);
        @(negedge clk);
        addr_load = 1'b1; addr_in = 9'(a);
        @(negedge clk);
        addr_load = 1'b0;
        m_page = a >> 4; m_ptr = a & 15; m_mask = '0;
    endtask

    task automatic put_byte(input logic [7:0] d);
        @(negedge clk);
        byte_valid = 1'b1; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
        m_buf[m_ptr] = d; m_mask[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) & 15;
    endtask

    // Issue stop and check busy against the model.
    task automatic end_txn(input logic prot, input string req);
        bit commit;
        int n;
        commit = (m_mask != 0) && !prot;
        @(negedge clk);
        stop = 1'b1; wp = prot;
        @(negedge clk);
        stop = 1'b0; wp = 1'b0;
        if (commit) begin
            n = 0;
            while (busy && n < 1000) begin
                n++;
                @(negedge clk);
            end
            chk(n == 16 + T, "R8 busy length", n, 16 + T);
            for (int s = 0; s < 16; s++)
                if (m_mask[s]) exp_mem[m_page * 16 + s] = m_buf[s];
        end else begin
            for (int k = 0; k < 3; k++) begin
                chk(busy == 1'b0, req, busy, 0);
                @(negedge clk);
            end
        end
        m_mask = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int a = 0; a < 512; a++) exp_mem[a] = 8'hFF;
        m_mask = '0; m_page = 0; m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        sweep("R1 erased");

        // R2 / R5: single byte, no write before stop
        set_addr(9'h0A5);
        put_byte(8'h3C);
        rd_addr = 9'h0A5; #0.1;
        chk(rd_data == 8'hFF, "R5 no write before stop", rd_data, 8'hFF);
        end_txn(1'b0, "R2");
        sweep("R2 byte write");

        // R3 full page from slot 0
        set_addr(7 * 16);
        for (int i = 0; i < 16; i++) put_byte(8'(i * 7 + 1));
        end_txn(1'b0, "R3");
        sweep("R3 full page");

        // R3 mid-page wrap stays in page
        set_addr(12 * 16 + 13);
        for (int i = 0; i < 6; i++) put_byte(8'(8'h50 + i));
        end_txn(1'b0, "R3");
        sweep("R3 wrap in page");

        // R4 overrun: 20 bytes from slot 4
        set_addr(20 * 16 + 4);
        for (int i = 0; i < 20; i++) put_byte(8'(8'h90 + i));
        end_txn(1'b0, "R4");
        sweep("R4 overrun last wins");

        // R6 write protect, then R7 stop after discard
        set_addr(9'h033);
        put_byte(8'h11);
        put_byte(8'h22);
        end_txn(1'b1, "R6 wp stop busy");
        end_txn(1'b0, "R7 stop after wp discard");
        sweep("R6 wp no write");

        // R7 stop with no bytes
        set_addr(9'h140);
        end_txn(1'b0, "R7 empty stop busy");

        // R9 strobes during busy
        set_addr(9'h061);
        put_byte(8'hE7);
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        repeat (2) @(negedge clk);
        addr_load = 1'b1; addr_in = 9'h1F0;
        @(negedge clk);
        addr_load = 1'b0; byte_valid = 1'b1; byte_data = 8'hAA;
        @(negedge clk);
        byte_valid = 1'b0; stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(busy == 1'b1, "R9 busy kept through stray strobes", busy, 1);
        while (busy) @(negedge clk);
        exp_mem[9'h061] = 8'hE7;
        m_mask = '0;
        end_txn(1'b0, "R9 stray byte not buffered");
        sweep("R9 ignored while busy");

        // R10 mask cleared after commit
        set_addr(3 * 16);
        for (int i = 0; i < 3; i++) put_byte(8'(8'hC0 + i));
        end_txn(1'b0, "R10");
        set_addr(4 * 16 + 8);
        put_byte(8'h5A);
        end_txn(1'b0, "R10");
        sweep("R10 stale after commit");

        // R10 mask cleared by address load
        set_addr(5 * 16);
        put_byte(8'h01);
        put_byte(8'h02);
        set_addr(6 * 16 + 10);
        put_byte(8'h77);
        end_txn(1'b0, "R10");
        sweep("R10 stale after reload");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule